// File: doc/BRIEF.md
# PCM Bit Clock and Frame Sync Generator

This block derives the serial bit clock and the frame sync of a PCM audio port from one of two source clocks. Both sources arrive as one-cycle enable pulses in the single system clock domain. The block selects one of them and divides it twice in cascade. A first divider makes the bit clock from the chosen source. A second divider counts bit clocks to mark frames.

A 20-bit configuration word drives the block:

| Bits | Meaning |
|------|---------|
| 19 | Enable |
| 18 | Source select |
| 17:9 | Bit-clock half-period divider D |
| 8:0 | Frame-length divider S |

A new divider value waits until the next frame boundary, so a frame is never cut short. Two activity inputs, one for each direction, and a mode input choose the idle behaviour:
- In gated mode the bit clock stops when both directions are idle.
- In continuous mode the bit clock keeps running.

One-cycle tick outputs mark each rising and each falling bit-clock edge, so a shifter can step on them. Software normally sets S to 127, which gives 128 bit clocks per frame.

Top module: `pcm_clkgen`

## Requirements
- R1: Bit 18 of `cfg_word` selects the source. When it is 1, `src_a_tick` pulses are counted. When it is 0, `src_b_tick` pulses are counted.
- R2: With D held in bits 17:9, `bclk` has a period of 2×(D+1) selected source ticks. It is high for the first D+1 ticks and low for the next D+1.
- R3: With S held in bits 8:0, the interval from one `fsync` rise to the next is S+1 bit-clock periods (for S ≥ 1).
- R4: `fsync` rises in the same cycle as the `bclk` rise that opens slot 0 of a frame. It stays high for exactly one bit-clock period.
- R5: When bit 19 is 0, `bclk` and `fsync` go low at the next clock edge and stay low. The counters restart when the block is enabled again.
- R6: When `tx_active`, `rx_active` and `idle_cont` are all 0, `bclk` rests low. When `idle_cont` is 1 and bit 19 is 1, `bclk` keeps toggling even with both directions idle.
- R7: A change to D or S while running takes effect only at the next frame boundary. Every frame interval therefore equals either the old length or the new length.
- R8: `bit_tick` is high for one cycle together with every `bclk` rise. `fall_tick` is high for one cycle together with every `bclk` fall. Neither is high at any other time.
- R9: During reset, `bclk`, `fsync`, `bit_tick` and `fall_tick` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_a_tick | input | 1 | Enable pulse of the first source clock |
| src_b_tick | input | 1 | Enable pulse of the second source clock |
| cfg_word | input | 2*DIV_W+2 | Bit 19 enable, bit 18 source select, bits 17:9 D, bits 8:0 S |
| tx_active | input | 1 | Transmit direction is active |
| rx_active | input | 1 | Receive direction is active |
| idle_cont | input | 1 | 1 = continuous idle clock, 0 = gated |
| bclk | output | 1 | Serial bit clock level |
| fsync | output | 1 | Frame sync, one bit clock wide |
| bit_tick | output | 1 | One-cycle pulse with each bclk rise |
| fall_tick | output | 1 | One-cycle pulse with each bclk fall |

## Verification
A wrong half-period counter or a wrong divider latch shows up within one bit period as a `bclk` high or low phase of the wrong length. A wrong slot counter or a wrong frame-boundary reload shows up as an `fsync` spacing that matches neither the old frame length nor the new one. A stale enable or stale gating decision is visible one cycle after the inputs change, as `bclk` failing to drop low. The bench sweeps D, S and both sources, and measures every phase and interval in system cycles.

// File: rtl/pcm_clkgen.sv
module pcm_clkgen #(
  parameter int DIV_W = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               src_a_tick,
  input  logic               src_b_tick,
  input  logic [2*DIV_W+1:0] cfg_word,
  input  logic               tx_active,
  input  logic               rx_active,
  input  logic               idle_cont,
  output logic               bclk,
  output logic               fsync,
  output logic               bit_tick,
  output logic               fall_tick
);
  localparam int SEL_BIT = 2*DIV_W;
  localparam int EN_BIT  = 2*DIV_W + 1;

  logic [DIV_W-1:0] half_cnt, slot_cnt, bdiv_cur, sync_cur;
  logic             first_q;

  wire run      = cfg_word[EN_BIT] & (tx_active | rx_active | idle_cont);
  wire src_tick = cfg_word[SEL_BIT] ? src_a_tick : src_b_tick;
  wire half_end = src_tick && (half_cnt == bdiv_cur);
  wire rise     = half_end && !bclk;
  wire fall     = half_end && bclk;
  wire wrap     = first_q || (slot_cnt == sync_cur);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      half_cnt  <= '0;
      slot_cnt  <= '0;
      bdiv_cur  <= '0;
      sync_cur  <= '0;
      first_q   <= 1'b1;
      bclk      <= 1'b0;
      fsync     <= 1'b0;
      bit_tick  <= 1'b0;
      fall_tick <= 1'b0;
    end else if (!run) begin
      half_cnt  <= '0;
      slot_cnt  <= '0;
      bdiv_cur  <= cfg_word[2*DIV_W-1:DIV_W];
      sync_cur  <= cfg_word[DIV_W-1:0];
      first_q   <= 1'b1;
      bclk      <= 1'b0;
      fsync     <= 1'b0;
      bit_tick  <= 1'b0;
      fall_tick <= 1'b0;
    end else begin
      bit_tick  <= rise;
      fall_tick <= fall;
      if (src_tick) half_cnt <= half_end ? '0 : half_cnt + 1'b1;
      if (half_end) bclk <= ~bclk;
      if (rise) begin
        first_q <= 1'b0;
        if (wrap) begin
          slot_cnt <= '0;
          fsync    <= 1'b1;
          bdiv_cur <= cfg_word[2*DIV_W-1:DIV_W];
          sync_cur <= cfg_word[DIV_W-1:0];
        end else begin
          slot_cnt <= slot_cnt + 1'b1;
          fsync    <= 1'b0;
        end
      end
    end
  end
endmodule

module pcm_clkgen_chk #(
  parameter int DIV_W = 9
) (
  input logic               clk,
  input logic               rst_n,
  input logic               src_a_tick,
  input logic               src_b_tick,
  input logic [2*DIV_W+1:0] cfg_word,
  input logic               tx_active,
  input logic               rx_active,
  input logic               idle_cont,
  input logic               bclk,
  input logic               fsync,
  input logic               bit_tick,
  input logic               fall_tick
);
  localparam int SEL_BIT = 2*DIV_W;
  localparam int EN_BIT  = 2*DIV_W + 1;

  assert_rise_on_src_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bclk) |-> $past(cfg_word[SEL_BIT] ? src_a_tick : src_b_tick));

  assert_sync_with_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fsync) |-> $rose(bclk));

  assert_disabled_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_word[EN_BIT] |=> (!bclk && !fsync));

  assert_gated_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_active && !rx_active && !idle_cont) |=> !bclk);

  assert_rise_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> (bclk && !$past(bclk)));

  assert_fall_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fall_tick |-> (!bclk && $past(bclk)));
endmodule

bind pcm_clkgen pcm_clkgen_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_a_tick(src_a_tick), .src_b_tick(src_b_tick),
  .cfg_word(cfg_word), .tx_active(tx_active), .rx_active(rx_active),
  .idle_cont(idle_cont), .bclk(bclk), .fsync(fsync), .bit_tick(bit_tick),
  .fall_tick(fall_tick)
);

// File: tb/pcm_clkgen_tb.sv
module pcm_clkgen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int B_PER = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        src_b_tick;
  logic [19:0] cfg_word = '0;
  logic        tx_active = 1'b0, rx_active = 1'b0, idle_cont = 1'b0;
  logic        bclk, fsync, bit_tick, fall_tick;
  int          tests = 0, fails = 0, bcnt = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) bcnt <= (bcnt == B_PER-1) ? 0 : bcnt + 1;
  assign src_b_tick = (bcnt == 0);

  pcm_clkgen u_dut (
    .clk(clk), .rst_n(rst_n), .src_a_tick(1'b1), .src_b_tick(src_b_tick),
    .cfg_word(cfg_word), .tx_active(tx_active), .rx_active(rx_active),
    .idle_cont(idle_cont), .bclk(bclk), .fsync(fsync), .bit_tick(bit_tick),
    .fall_tick(fall_tick)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [19:0] mk(input bit en, input bit sel, input int d, input int s);
    return {en, sel, d[8:0], s[8:0]};
  endfunction

  task automatic measure(input bit sel, input int d, input int s);
    int p = sel ? 1 : B_PER;
    int bper = 2 * (d + 1) * p;
    int fper = (s + 1) * bper;
    int n = fper * 3 + 40;
    int last_br = -1, last_fr = -1, last_bf = -1;
    int bad_b = 0, bad_f = 0, bad_w = 0, bad_t = 0, bad_h = 0;
    int got_b = 0, got_f = 0, got_w = 0, got_h = 0;
    int nf = 0, nb = 0;
    logic pb = 1'b0, pf = 1'b0;
    @(negedge clk);
    cfg_word = mk(1'b0, sel, d, s);
    repeat (2) @(negedge clk);
    cfg_word = mk(1'b1, sel, d, s);
    tx_active = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (bit_tick != (bclk && !pb)) bad_t++;
      if (fall_tick != (!bclk && pb)) bad_t++;
      if (bclk && !pb) begin
        if (last_br >= 0 && i - last_br != bper) begin bad_b++; got_b = i - last_br; end
        last_br = i; nb++;
      end
      if (!bclk && pb) begin
        if (i - last_br != (d + 1) * p) begin bad_h++; got_h = i - last_br; end
        last_bf = i;
      end
      if (fsync && !pf) begin
        if (!(bclk && !pb)) bad_w++;
        if (last_fr >= 0 && i - last_fr != fper) begin bad_f++; got_f = i - last_fr; end
        last_fr = i; nf++;
      end
      if (!fsync && pf && i - last_fr != bper) begin bad_w++; got_w = i - last_fr; end
      pb = bclk; pf = fsync;
    end
    check(bad_b == 0 && nb > 2, sel ? "R2 bclk period" : "R1 R2 bclk period on src_b", got_b, bper);
    check(bad_h == 0, "R2 bclk high phase", got_h, (d + 1) * p);
    check(bad_f == 0 && nf >= 2, "R3 frame interval", got_f, fper);
    check(bad_w == 0, "R4 fsync width", got_w, bper);
    check(bad_t == 0, "R8 edge ticks", bad_t, 0);
    tx_active = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!bclk && !fsync && !bit_tick && !fall_tick, "R9 reset outputs",
          {bclk, fsync, bit_tick, fall_tick}, 0);
    rst_n = 1'b1;

    for (int sel = 0; sel < 2; sel++)
      for (int d = 0; d < 4; d++)
        for (int s = 1; s < 5; s++)
          measure(sel[0], d, s);

    begin
      int hi = 0;
      @(negedge clk);
      cfg_word = mk(1'b1, 1'b1, 0, 3);
      tx_active = 1'b1;
      repeat (20) @(negedge clk);
      cfg_word = mk(1'b0, 1'b1, 0, 3);
      @(negedge clk);
      for (int i = 0; i < 30; i++) begin
        if (bclk || fsync) hi++;
        @(negedge clk);
      end
      check(hi == 0, "R5 disabled outputs low", hi, 0);
      tx_active = 1'b0;
    end

    begin
      int hi = 0, rises = 0;
      logic pb = 1'b0;
      cfg_word = mk(1'b1, 1'b1, 1, 3);
      idle_cont = 1'b0;
      @(negedge clk);
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (bclk) hi++;
      end
      check(hi == 0, "R6 gated idle stops bclk", hi, 0);
      idle_cont = 1'b1;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (bclk && !pb) rises++;
        pb = bclk;
      end
      check(rises >= 9, "R6 continuous idle runs bclk", rises, 10);
      idle_cont = 1'b0;
    end

    begin
      int old_l = 16, new_l = 18, bad = 0, last = -1, iv = 0, lastiv = 0;
      logic pf = 1'b0;
      cfg_word = mk(1'b0, 1'b1, 1, 3);
      repeat (2) @(negedge clk);
      cfg_word = mk(1'b1, 1'b1, 1, 3);
      rx_active = 1'b1;
      for (int i = 0; i < 200; i++) begin
        @(negedge clk);
        if (i == 57) cfg_word = mk(1'b1, 1'b1, 2, 2);
        if (fsync && !pf) begin
          if (last >= 0) begin
            iv = i - last;
            if (iv != old_l && iv != new_l) bad++;
            lastiv = iv;
          end
          last = i;
        end
        pf = fsync;
      end
      check(bad == 0, "R7 no short frame on change", iv, new_l);
      check(lastiv == new_l, "R7 new length applied", lastiv, new_l);
      rx_active = 1'b0;
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule